// File: doc/BRIEF.md
# Redundant Load Value Queue

This block sits between two redundant copies of one thread. The leading copy is the only one that reads the data cache. Every load it completes pushes its address and the returned value into an in-order queue. The trailing copy never goes to the cache. Each of its loads pops the oldest entry, so both copies consume the same input value even if memory is changed in the meantime by I/O or by another agent.

The two copies do not run in lock-step. The leading copy may run ahead by as many loads as the queue holds. A full queue stalls the leading side, and an empty queue stalls a trailing request. Each trailing load presents its own address. If that address differs from the stored address of the entry it consumes, a sticky fault flag is raised for the recovery logic outside this block.

Top module: `redundant_load_queue`

## Requirements
- R1: After reset, count_o is 0, empty_o is 1, full_o is 0, trail_ready_o is 0, lead_ready_o is 1 and mismatch_o is 0.
- R2: When lead_valid_i and lead_ready_o are both high at a clock edge, the pair (lead_addr_i, lead_data_i) is appended to the tail of the queue.
- R3: When the queue holds DEPTH entries, full_o is 1 and lead_ready_o is 0. A lead_valid_i in that state is ignored: no entry is stored, and later pops show none of its data.
- R4: When the queue is empty, empty_o is 1 and trail_ready_o is 0. A trail_valid_i in that state is ignored: count_o stays the same and mismatch_o is not set.
- R5: Whenever the queue is not empty, trail_data_o shows the data of the oldest entry. The k-th pop returns the data of the k-th push.
- R6: A push and a pop accepted in the same cycle leave count_o unchanged.
- R7: A pop (trail_valid_i and trail_ready_o both high) whose trail_addr_i differs from the stored address of the popped entry sets mismatch_o from the next cycle on. mismatch_o stays set until reset.
- R8: A pop whose trail_addr_i equals the stored address leaves mismatch_o unchanged.
- R9: The leading side can get up to 64 entries ahead (default DEPTH) without a single pop.
- R10: count_o always equals the number of stored entries, from 0 to DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lead_valid_i | input | 1 | Leading load result available |
| lead_addr_i | input | ADDR_W | Address of the leading load |
| lead_data_i | input | DATA_W | Value returned to the leading load |
| lead_ready_o | output | 1 | Queue can accept a push |
| trail_valid_i | input | 1 | Trailing load requests its value |
| trail_addr_i | input | ADDR_W | Address of the trailing load |
| trail_ready_o | output | 1 | An entry is available to pop |
| trail_data_o | output | DATA_W | Value of the oldest entry |
| full_o | output | 1 | Queue holds DEPTH entries |
| empty_o | output | 1 | Queue holds no entries |
| count_o | output | $clog2(DEPTH+1) | Current occupancy |
| mismatch_o | output | 1 | Sticky address mismatch fault |

## Verification
The bench fills the queue to exactly 64 entries and keeps pushing. A design that overflowed would corrupt the oldest entry or lose the count, and the ordered drain that follows would show it. It also pops while the queue is full and pushes into an empty queue while a trailing request is active. This catches a design that bypasses a same-cycle push straight to the trailing side, or that lets an empty pop move the read pointer. It injects one wrong trailing address among many correct ones. A design that compared against the wrong entry, or that did not hold the flag, would show mismatch_o at the wrong time or drop it later. A long random mix of push and pop rates checks the count during simultaneous push and pop.

// File: rtl/lvq_pkg.sv
package lvq_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_BOTH = 2'b11
  } lvq_op_e;
endpackage

// File: rtl/lvq_ptr.sv
module lvq_ptr #(
  parameter int DEPTH = 64,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [PW-1:0] ptr_o
);
  logic [PW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (adv_i) ptr_q <= (ptr_q == PW'(DEPTH-1)) ? '0 : ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/lvq_store.sv
module lvq_store #(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [PW-1:0]     wptr_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [PW-1:0]     rptr_i,
  output logic [ADDR_W-1:0] raddr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [ADDR_W-1:0] addr_mem [DEPTH];
  logic [DATA_W-1:0] data_mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      addr_mem[wptr_i] <= waddr_i;
      data_mem[wptr_i] <= wdata_i;
    end
  end

  assign raddr_o = addr_mem[rptr_i];
  assign rdata_o = data_mem[rptr_i];
endmodule

// File: rtl/lvq_check.sv
module lvq_check #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pop_i,
  input  logic [ADDR_W-1:0] head_addr_i,
  input  logic [ADDR_W-1:0] trail_addr_i,
  output logic              mismatch_o
);
  logic mism_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 mism_q <= 1'b0;
    else if (pop_i && head_addr_i != trail_addr_i) mism_q <= 1'b1;
  end

  assign mismatch_o = mism_q;

  assert_mismatch_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mism_q |=> mism_q);
  assert_match_keeps_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mism_q && !(pop_i && head_addr_i != trail_addr_i)) |=> !mism_q);
endmodule

// File: rtl/redundant_load_queue.sv
module redundant_load_queue
  import lvq_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lead_valid_i,
  input  logic [ADDR_W-1:0] lead_addr_i,
  input  logic [DATA_W-1:0] lead_data_i,
  output logic              lead_ready_o,
  input  logic              trail_valid_i,
  input  logic [ADDR_W-1:0] trail_addr_i,
  output logic              trail_ready_o,
  output logic [DATA_W-1:0] trail_data_o,
  output logic              full_o,
  output logic              empty_o,
  output logic [CW-1:0]     count_o,
  output logic              mismatch_o
);
  logic [CW-1:0]     count_q;
  logic [PW-1:0]     wptr, rptr;
  logic [ADDR_W-1:0] head_addr;
  logic              push, pop;
  lvq_op_e           op;

  assign full_o        = (count_q == CW'(DEPTH));
  assign empty_o       = (count_q == '0);
  assign lead_ready_o  = !full_o;
  assign trail_ready_o = !empty_o;
  // no bypass: an empty queue stalls the trailer even on a same-cycle push
  assign push = lead_valid_i  && lead_ready_o;
  assign pop  = trail_valid_i && trail_ready_o;
  assign op   = lvq_op_e'({pop, push});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else begin
      case (op)
        OP_PUSH: count_q <= count_q + 1'b1;
        OP_POP:  count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign count_o = count_q;

  lvq_ptr #(.DEPTH(DEPTH)) u_wptr (.clk_i, .rst_ni, .adv_i(push), .ptr_o(wptr));
  lvq_ptr #(.DEPTH(DEPTH)) u_rptr (.clk_i, .rst_ni, .adv_i(pop),  .ptr_o(rptr));

  lvq_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk_i, .we_i(push), .wptr_i(wptr), .waddr_i(lead_addr_i), .wdata_i(lead_data_i),
    .rptr_i(rptr), .raddr_o(head_addr), .rdata_o(trail_data_o));

  lvq_check #(.ADDR_W(ADDR_W)) u_check (
    .clk_i, .rst_ni, .pop_i(pop), .head_addr_i(head_addr),
    .trail_addr_i(trail_addr_i), .mismatch_o(mismatch_o));

  assert_count_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH));
  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !trail_valid_i) |=> full_o && $stable(count_o));
  assert_no_underflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && !lead_valid_i) |=> empty_o && $stable(mismatch_o));
  assert_push_pop_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lead_valid_i && lead_ready_o && trail_valid_i && trail_ready_o) |=> $stable(count_o));
  assert_push_grows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lead_valid_i && lead_ready_o && !trail_valid_i) |=> count_o == $past(count_o) + 1'b1);
endmodule

// File: tb/sim_redundant_load_queue.sv
module sim_redundant_load_queue;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 64;
  localparam int CW     = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic lead_valid = 1'b0, trail_valid = 1'b0;
  logic [31:0] lead_addr = '0, lead_data = '0, trail_addr = '0;
  logic lead_ready, trail_ready, full, empty, mismatch;
  logic [31:0] trail_data;
  logic [CW-1:0] count;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct { logic [31:0] a; logic [31:0] d; } ent_t;
  ent_t mq[$];
  bit   m_mism = 0;

  always #(PERIOD/2) clk = ~clk;

  redundant_load_queue #(.DEPTH(DEPTH), .ADDR_W(32), .DATA_W(32)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .lead_valid_i(lead_valid), .lead_addr_i(lead_addr), .lead_data_i(lead_data),
    .lead_ready_o(lead_ready),
    .trail_valid_i(trail_valid), .trail_addr_i(trail_addr),
    .trail_ready_o(trail_ready), .trail_data_o(trail_data),
    .full_o(full), .empty_o(empty), .count_o(count), .mismatch_o(mismatch));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // compare every output with the model; scen names the requirement under stimulus
  task automatic compare(input string scen);
    int n = mq.size();
    chk(count == CW'(n), "R10", {scen, " count"}, 64'(count), 64'(n));
    chk(full == (n == DEPTH) && lead_ready == (n != DEPTH), "R3", {scen, " full/ready"},
        64'({full, lead_ready}), 64'({n == DEPTH, n != DEPTH}));
    chk(empty == (n == 0) && trail_ready == (n != 0), "R4", {scen, " empty/ready"},
        64'({empty, trail_ready}), 64'({n == 0, n != 0}));
    chk(mismatch == m_mism, "R7", {scen, " mismatch"}, 64'(mismatch), 64'(m_mism));
    if (n != 0) chk(trail_data == mq[0].d, "R5", {scen, " head data"},
                    64'(trail_data), 64'(mq[0].d));
  endtask

  task automatic step(input string scen, input bit lv, input logic [31:0] la,
                      input logic [31:0] ld, input bit tv, input bit bad);
    bit do_push, do_pop;
    logic [31:0] ta;
    compare(scen);
    ta = (mq.size() != 0) ? (bad ? mq[0].a ^ 32'h4 : mq[0].a) : 32'hdead_0000;
    lead_valid = lv; lead_addr = la; lead_data = ld;
    trail_valid = tv; trail_addr = ta;
    do_push = lv && mq.size() < DEPTH;
    do_pop  = tv && mq.size() > 0;
    if (do_pop) begin
      if (ta != mq[0].a) m_mism = 1;
      void'(mq.pop_front());
    end
    if (do_push) mq.push_back('{la, ld});
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    lead_valid = 0; trail_valid = 0;
    mq.delete(); m_mism = 0;
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk(count == 0 && empty && !full && !trail_ready && lead_ready && !mismatch, "R1",
        "reset state", 64'({count, empty, full, trail_ready, lead_ready, mismatch}),
        64'({7'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}));

    // R4: trailing request on empty queue is ignored
    for (int i = 0; i < 3; i++) step("R4", 0, 0, 0, 1, 1);
    // R4 with a same-cycle push: trailer still stalls
    step("R4", 1, 32'h1000, 32'haaaa_0001, 1, 1);
    step("R4", 0, 0, 0, 1, 0);

    // R2/R9: leading runs ahead to full capacity
    for (int i = 0; i < DEPTH; i++)
      step("R9", 1, 32'h2000 + 32'(i*4), 32'hc0de_0000 + 32'(i), 0, 0);
    // R3: pushes while full are ignored
    for (int i = 0; i < 4; i++) step("R3", 1, 32'hffff_0000, 32'hbad0_bad0, 0, 0);
    // R3: pop while full with a blocked push
    step("R3", 1, 32'hffff_0004, 32'hbad1_bad1, 1, 0);
    // R5/R8: ordered drain, matching addresses
    for (int i = 0; i < DEPTH + 2; i++) step("R5", 0, 0, 0, 1, 0);
    chk(mismatch == 0, "R8", "no fault after matching drain", 64'(mismatch), 0);

    // R6: steady push and pop at mid occupancy
    for (int i = 0; i < 10; i++) step("R2", 1, 32'h3000 + 32'(i*8), 32'h5eed_0000 + 32'(i), 0, 0);
    for (int i = 0; i < 20; i++) step("R6", 1, 32'h4000 + 32'(i*8), 32'h7777_0000 + 32'(i), 1, 0);

    // random mix, matching addresses
    for (int i = 0; i < 600; i++)
      step("R10", ($urandom % 4) != 0, $urandom, $urandom, ($urandom % 3) != 0, 0);

    // R7: one wrong trailing address, then flag must hold
    for (int i = 0; i < 4; i++) step("R2", 1, 32'h5000 + 32'(i), 32'h1234_0000 + 32'(i), 0, 0);
    step("R7", 0, 0, 0, 1, 1);
    for (int i = 0; i < 6; i++) step("R7", 1, 32'h6000 + 32'(i), 32'h9 + 32'(i), 1, 0);
    chk(mismatch == 1, "R7", "flag held", 64'(mismatch), 1);

    // R1: reset clears queue and flag
    do_reset();
    chk(count == 0 && empty && !mismatch, "R1", "reset after fault",
        64'({count, empty, mismatch}), 64'({7'd0, 1'b1, 1'b0}));
    step("R1", 0, 0, 0, 0, 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule